// File: doc/BRIEF.md
# Control Endpoint Receive Responder

This block sits beside the serial engine of a low-speed USB device and decides how the control endpoint answers SETUP and OUT transactions. The serial engine reports a decoded token with a strobe, and later the end of the data packet that follows it. For that packet it supplies an error flag, the received byte count (data bytes plus the two CRC bytes) and the received data toggle. From three firmware control bits the block then chooses five things independently: whether the packet goes into the shared 8-byte endpoint FIFO, whether the toggle is recorded, whether the count is recorded, whether the processor is interrupted, and which handshake is sent.

The block keeps an 8-bit receive status word that the processor reads and clears with a write. While a SETUP has been flagged, the block holds firmware FIFO writes blocked, so that setup data cannot be overwritten. A processor clear cannot remove the SETUP flag while the data phase of that SETUP is still arriving. Serial decoding, CRC checking and the FIFO storage lie outside the block.

Top module: `ctl_ep_rx_responder`

## Requirements
- R1: After reset, `rx_stat`, `rx_invalid`, `fifo_blk`, `irq`, `fifo_wr`, `fifo_len` and `hs_vld` are all zero.
- R2: `rx_stat` layout is bit0 SETUP, bit1 OUT, bit2 IN, bit3 toggle, bits 7:4 count. A token strobe with `tok_type` 2'b01 (OUT) sets the OUT bit and clears the IN bit. A strobe with 2'b10 (IN) sets the IN bit and clears the OUT bit. A strobe with 2'b00 (SETUP) clears both and sets the SETUP bit. Code 2'b11 has no effect on the status word. OUT and IN are never both set.
- R3: `fifo_blk` is high exactly while the SETUP bit of `rx_stat` is set.
- R4: `cpu_wr` clears every bit of `rx_stat` except the toggle, which keeps its value. When the write arrives between a SETUP token and the end of its data packet, the SETUP bit is kept as well.
- R5: The data packet after SETUP always writes the FIFO, always records toggle and count, and always raises `irq`. It is answered ACK (code 0) when error-free and with no handshake (code 3) on error.
- R6: For OUT data with `ctl_stall`=0, `ctl_status`=0 and `ctl_out_en`=1, the block writes the FIFO, records toggle and count, raises `irq`, and answers ACK. On error it gives no handshake.
- R7: For OUT data with all three control bits 0, the block changes no status, writes nothing and raises no `irq`. It answers NAK (code 1), or gives no handshake on error.
- R8: For OUT data with `ctl_stall`=1, whatever the other two bits are, the block changes no status, writes nothing and raises no `irq`. It answers STALL (code 2), or gives no handshake on error.
- R9: For OUT data with `ctl_status`=1 and `ctl_stall`=0, the FIFO is never written. A status stage (toggle 1, count 2, no error) records toggle and count, raises `irq` and is answered ACK. Any other error-free packet does the same but is answered STALL. An errored packet records only the toggle, raises no `irq` and gets no handshake.
- R10: A packet is in error when `dat_err` is set or when its count exceeds 10 (more than 8 data bytes). `rx_invalid` is set by an errored data packet and cleared by an error-free one.
- R11: When `fifo_wr` pulses, `fifo_len` equals the received count capped at 8.
- R12: `irq`, `fifo_wr` and `hs_vld` are one-cycle pulses, issued one clock after `dat_done`, in the same cycle in which `rx_stat` shows the committed values. A `dat_done` with no SETUP or OUT data phase open (for instance after an IN token) produces none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_vld | input | 1 | Valid token strobe for this endpoint |
| tok_type | input | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN, 3 unused |
| dat_done | input | 1 | End-of-data-packet strobe |
| dat_err | input | 1 | Packet had a CRC, PID or bit-stuffing error |
| dat_cnt | input | 4 | Received bytes including two CRC bytes |
| dat_tgl | input | 1 | Received data toggle (1 = DATA1) |
| ctl_stall | input | 1 | Stall control bit |
| ctl_status | input | 1 | Automatic status-stage answer control bit |
| ctl_out_en | input | 1 | Accept-OUT-data control bit |
| cpu_wr | input | 1 | Processor write to the status word |
| rx_stat | output | 8 | Receive status word |
| rx_invalid | output | 1 | Last data packet was in error |
| fifo_blk | output | 1 | Firmware FIFO writes blocked |
| fifo_wr | output | 1 | Write the packet into the FIFO |
| fifo_len | output | 4 | Bytes to write into the FIFO |
| irq | output | 1 | Endpoint interrupt pulse |
| hs_vld | output | 1 | Handshake decision strobe |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 none |

## Verification
The hardest case to reach is a processor clear that lands inside a SETUP data phase. It must keep the SETUP flag, and the same kind of clear issued after commit must remove it. The stimulus issues the SETUP token, clears before the data strobe, then clears again afterwards. A second hard case is the status-stage classification, which depends on toggle and count together. The bench sends DATA1 with count 2, DATA0 with count 2, and a longer packet under the same control setting. It also checks that errored packets under that setting change only the toggle.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

    localparam int CNT_W      = 4;
    localparam int FIFO_BYTES = 8;
    localparam int CRC_BYTES  = 2;
    localparam int MAX_CNT    = FIFO_BYTES + CRC_BYTES;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_NONE  = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_OUT   = 2'd2
    } phase_e;

    // Packed so that setup_f lands on bit 0 and cnt on the top nibble.
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tgl;
        logic             in_f;
        logic             out_f;
        logic             setup_f;
    } rxstat_t;

    typedef struct packed {
        logic fifo_wr;
        logic upd_tgl;
        logic upd_cnt;
        logic irq;
        hs_e  hs;
    } resp_t;

    function automatic logic is_status_stage(logic [CNT_W-1:0] cnt, logic tgl);
        return tgl && (cnt == CNT_W'(CRC_BYTES));
    endfunction

    function automatic logic is_overlong(logic [CNT_W-1:0] cnt);
        return cnt > CNT_W'(MAX_CNT);
    endfunction

    function automatic logic [CNT_W-1:0] fifo_bytes(logic [CNT_W-1:0] cnt);
        return (cnt > CNT_W'(FIFO_BYTES)) ? CNT_W'(FIFO_BYTES) : cnt;
    endfunction

    function automatic resp_t nothing(hs_e hs);
        resp_t r;
        r.fifo_wr = 1'b0;
        r.upd_tgl = 1'b0;
        r.upd_cnt = 1'b0;
        r.irq     = 1'b0;
        r.hs      = hs;
        return r;
    endfunction

endpackage

// File: rtl/ctl_ep_phase.sv
module ctl_ep_phase
    import ctl_ep_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tok_vld,
    input  tok_e   tok,
    input  logic   dat_done,
    output phase_e phase,
    output logic   commit
);

    phase_e phase_q, phase_d;

    assign commit = dat_done && (phase_q != PH_IDLE);
    assign phase  = phase_q;

    always_comb begin
        phase_d = phase_q;
        if (commit) begin
            phase_d = PH_IDLE;
        end
        if (tok_vld) begin
            unique case (tok)
                TK_SETUP: phase_d = PH_SETUP;
                TK_OUT:   phase_d = PH_OUT;
                TK_IN:    phase_d = PH_IDLE;
                default:  phase_d = phase_d;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/ctl_ep_decide.sv
module ctl_ep_decide
    import ctl_ep_pkg::*;
(
    input  phase_e           phase,
    input  logic             dat_err,
    input  logic [CNT_W-1:0] dat_cnt,
    input  logic             dat_tgl,
    input  logic             ctl_stall,
    input  logic             ctl_status,
    input  logic             ctl_out_en,
    output resp_t            resp,
    output logic             bad,
    output logic [CNT_W-1:0] len
);

    logic stat_ok;

    assign bad     = dat_err || is_overlong(dat_cnt);
    assign stat_ok = is_status_stage(dat_cnt, dat_tgl);
    assign len     = fifo_bytes(dat_cnt);

    always_comb begin
        resp = nothing(HS_NONE);
        unique case (phase)
            PH_SETUP: begin
                resp.fifo_wr = 1'b1;
                resp.upd_tgl = 1'b1;
                resp.upd_cnt = 1'b1;
                resp.irq     = 1'b1;
                resp.hs      = bad ? HS_NONE : HS_ACK;
            end
            PH_OUT: begin
                if (ctl_stall) begin
                    resp = nothing(bad ? HS_NONE : HS_STALL);
                end else if (ctl_status) begin
                    resp.upd_tgl = 1'b1;
                    if (bad) begin
                        resp.hs = HS_NONE;
                    end else begin
                        resp.upd_cnt = 1'b1;
                        resp.irq     = 1'b1;
                        resp.hs      = stat_ok ? HS_ACK : HS_STALL;
                    end
                end else if (ctl_out_en) begin
                    resp.fifo_wr = 1'b1;
                    resp.upd_tgl = 1'b1;
                    resp.upd_cnt = 1'b1;
                    resp.irq     = 1'b1;
                    resp.hs      = bad ? HS_NONE : HS_ACK;
                end else begin
                    resp = nothing(bad ? HS_NONE : HS_NAK);
                end
            end
            default: resp = nothing(HS_NONE);
        endcase
    end

endmodule

// File: rtl/ctl_ep_statreg.sv
module ctl_ep_statreg
    import ctl_ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_vld,
    input  tok_e             tok,
    input  logic             cpu_wr,
    input  logic             setup_busy,
    input  logic             commit,
    input  resp_t            resp,
    input  logic             bad,
    input  logic [CNT_W-1:0] dat_cnt,
    input  logic             dat_tgl,
    output rxstat_t          stat,
    output logic             invalid
);

    rxstat_t stat_q, stat_d;
    logic    inv_q;

    always_comb begin
        stat_d = stat_q;
        if (cpu_wr) begin
            stat_d.cnt   = '0;
            stat_d.in_f  = 1'b0;
            stat_d.out_f = 1'b0;
            if (!setup_busy) begin
                stat_d.setup_f = 1'b0;
            end
        end
        if (tok_vld && (tok != TK_RSVD)) begin
            stat_d.out_f = (tok == TK_OUT);
            stat_d.in_f  = (tok == TK_IN);
            if (tok == TK_SETUP) begin
                stat_d.setup_f = 1'b1;
            end
        end
        if (commit) begin
            if (resp.upd_tgl) stat_d.tgl = dat_tgl;
            if (resp.upd_cnt) stat_d.cnt = dat_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            inv_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            if (commit) begin
                inv_q <= bad;
            end
        end
    end

    assign stat    = stat_q;
    assign invalid = inv_q;

endmodule

// File: rtl/ctl_ep_rx_responder.sv
module ctl_ep_rx_responder
    import ctl_ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_vld,
    input  logic [1:0]       tok_type,
    input  logic             dat_done,
    input  logic             dat_err,
    input  logic [CNT_W-1:0] dat_cnt,
    input  logic             dat_tgl,
    input  logic             ctl_stall,
    input  logic             ctl_status,
    input  logic             ctl_out_en,
    input  logic             cpu_wr,
    output logic [7:0]       rx_stat,
    output logic             rx_invalid,
    output logic             fifo_blk,
    output logic             fifo_wr,
    output logic [CNT_W-1:0] fifo_len,
    output logic             irq,
    output logic             hs_vld,
    output logic [1:0]       hs_code
);

    tok_e             tok;
    phase_e           phase;
    logic             commit;
    resp_t            resp;
    logic             bad;
    logic [CNT_W-1:0] len;
    rxstat_t          stat;

    logic             irq_q, fwr_q, hsv_q;
    logic [CNT_W-1:0] len_q;
    hs_e              hs_q;

    assign tok = tok_e'(tok_type);

    ctl_ep_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .tok_vld  (tok_vld),
        .tok      (tok),
        .dat_done (dat_done),
        .phase    (phase),
        .commit   (commit)
    );

    ctl_ep_decide u_decide (
        .phase      (phase),
        .dat_err    (dat_err),
        .dat_cnt    (dat_cnt),
        .dat_tgl    (dat_tgl),
        .ctl_stall  (ctl_stall),
        .ctl_status (ctl_status),
        .ctl_out_en (ctl_out_en),
        .resp       (resp),
        .bad        (bad),
        .len        (len)
    );

    ctl_ep_statreg u_stat (
        .clk        (clk),
        .rst        (rst),
        .tok_vld    (tok_vld),
        .tok        (tok),
        .cpu_wr     (cpu_wr),
        .setup_busy (phase == PH_SETUP),
        .commit     (commit),
        .resp       (resp),
        .bad        (bad),
        .dat_cnt    (dat_cnt),
        .dat_tgl    (dat_tgl),
        .stat       (stat),
        .invalid    (rx_invalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            fwr_q <= 1'b0;
            hsv_q <= 1'b0;
            len_q <= '0;
            hs_q  <= HS_NONE;
        end else begin
            irq_q <= commit && resp.irq;
            fwr_q <= commit && resp.fifo_wr;
            hsv_q <= commit;
            len_q <= (commit && resp.fifo_wr) ? len : '0;
            hs_q  <= commit ? resp.hs : HS_NONE;
        end
    end

    assign rx_stat  = stat;
    assign fifo_blk = stat.setup_f;
    assign fifo_wr  = fwr_q;
    assign fifo_len = len_q;
    assign irq      = irq_q;
    assign hs_vld   = hsv_q;
    assign hs_code  = hs_q;

endmodule

// File: rtl/ctl_ep_rx_responder_chk.sv
module ctl_ep_rx_responder_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_wr,
    input logic [7:0] rx_stat,
    input logic       fifo_blk,
    input logic       fifo_wr,
    input logic [3:0] fifo_len,
    input logic       irq,
    input logic       hs_vld,
    input logic [1:0] hs_code
);

    p_flags_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(rx_stat[1] && rx_stat[2]));

    p_block_setup_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_blk == rx_stat[0]);

    p_tgl_only_commit_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_stat[3] != $past(rx_stat[3])) |-> hs_vld);

    p_nak_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (hs_vld && hs_code == 2'd1) |-> (!irq && !fifo_wr));

    p_stall_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (hs_vld && hs_code == 2'd2) |-> !fifo_wr);

    p_len_cap_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (fifo_len <= 4'd8));

    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_with_hs_r12: assert property (@(posedge clk) disable iff (rst)
        (irq || fifo_wr) |-> hs_vld);

    p_hs_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        hs_vld |=> !hs_vld);

    p_wr_kept_tgl_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(cpu_wr) && !hs_vld) |-> (rx_stat[7:4] == 4'd0));

endmodule

bind ctl_ep_rx_responder ctl_ep_rx_responder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_wr   (cpu_wr),
    .rx_stat  (rx_stat),
    .fifo_blk (fifo_blk),
    .fifo_wr  (fifo_wr),
    .fifo_len (fifo_len),
    .irq      (irq),
    .hs_vld   (hs_vld),
    .hs_code  (hs_code)
);

// File: tb/tb_ctl_ep_rx_responder.sv
module tb_ctl_ep_rx_responder;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tok_vld = 1'b0;
    logic [1:0] tok_type = 2'd0;
    logic       dat_done = 1'b0;
    logic       dat_err = 1'b0;
    logic [3:0] dat_cnt = 4'd0;
    logic       dat_tgl = 1'b0;
    logic       ctl_stall = 1'b0;
    logic       ctl_status = 1'b0;
    logic       ctl_out_en = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] rx_stat;
    logic       rx_invalid, fifo_blk, fifo_wr, irq, hs_vld;
    logic [3:0] fifo_len;
    logic [1:0] hs_code;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    ctl_ep_rx_responder dut (
        .clk(clk), .rst(rst), .tok_vld(tok_vld), .tok_type(tok_type),
        .dat_done(dat_done), .dat_err(dat_err), .dat_cnt(dat_cnt), .dat_tgl(dat_tgl),
        .ctl_stall(ctl_stall), .ctl_status(ctl_status), .ctl_out_en(ctl_out_en),
        .cpu_wr(cpu_wr), .rx_stat(rx_stat), .rx_invalid(rx_invalid), .fifo_blk(fifo_blk),
        .fifo_wr(fifo_wr), .fifo_len(fifo_len), .irq(irq), .hs_vld(hs_vld), .hs_code(hs_code)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tok(logic [1:0] t);
        @(negedge clk); tok_vld = 1'b1; tok_type = t;
        @(negedge clk); tok_vld = 1'b0;
    endtask

    task automatic clear_wr();
        @(negedge clk); cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic ctl(logic s, logic so, logic en);
        ctl_stall = s; ctl_status = so; ctl_out_en = en;
    endtask

    // Drives one data packet; returns at the cycle where results are visible.
    task automatic pkt(logic e, logic [3:0] c, logic g);
        @(negedge clk); dat_done = 1'b1; dat_err = e; dat_cnt = c; dat_tgl = g;
        @(negedge clk); dat_done = 1'b0; dat_err = 1'b0;
    endtask

    task automatic expect_out(string req, int st, int i, int fw, int ln, int hv, int hc);
        chk({req, " stat"}, rx_stat, st);
        chk({req, " irq"}, irq, i);
        chk({req, " fifo_wr"}, fifo_wr, fw);
        if (fw != 0) chk({req, " fifo_len"}, fifo_len, ln);
        chk({req, " hs_vld"}, hs_vld, hv);
        if (hv != 0) chk({req, " hs_code"}, hs_code, hc);
    endtask

    task automatic t_reset();
        chk("R1 stat", rx_stat, 0);
        chk("R1 invalid", rx_invalid, 0);
        chk("R1 blk", fifo_blk, 0);
        chk("R1 irq", irq, 0);
        chk("R1 fifo_wr", fifo_wr, 0);
        chk("R1 fifo_len", fifo_len, 0);
        chk("R1 hs_vld", hs_vld, 0);
    endtask

    task automatic t_setup_ok();
        tok(2'd0);
        chk("R3 setup flag", rx_stat, 8'h01);
        chk("R3 blk", fifo_blk, 1);
        clear_wr();
        chk("R4 setup kept in data phase", rx_stat, 8'h01);
        pkt(1'b0, 4'd10, 1'b0);
        expect_out("R5 setup ok", 8'hA1, 1, 1, 8, 1, 0);
        @(negedge clk);
        chk("R12 irq pulse", irq, 0);
        chk("R12 hs pulse", hs_vld, 0);
        chk("R12 fifo pulse", fifo_wr, 0);
        clear_wr();
        chk("R4 clear after commit", rx_stat, 8'h00);
        chk("R3 blk released", fifo_blk, 0);
    endtask

    task automatic t_setup_err();
        tok(2'd0);
        pkt(1'b1, 4'd5, 1'b1);
        expect_out("R5 setup err", 8'h59, 1, 1, 5, 1, 3);
        chk("R10 invalid set", rx_invalid, 1);
        clear_wr();
        chk("R4 toggle kept", rx_stat, 8'h08);
    endtask

    task automatic t_out_accept();
        ctl(1'b0, 1'b0, 1'b1);
        tok(2'd1);
        chk("R2 out flag", rx_stat, 8'h0A);
        pkt(1'b0, 4'd4, 1'b0);
        expect_out("R6 out ok", 8'h42, 1, 1, 4, 1, 0);
        chk("R10 invalid cleared", rx_invalid, 0);
        tok(2'd1);
        pkt(1'b0, 4'd11, 1'b1);
        expect_out("R10 overlong", 8'hBA, 1, 1, 8, 1, 3);
        chk("R10 overlong invalid", rx_invalid, 1);
        chk("R11 capped len", fifo_len, 8);
    endtask

    task automatic t_out_nak();
        ctl(1'b0, 1'b0, 1'b0);
        clear_wr();
        tok(2'd1);
        chk("R2 out flag again", rx_stat, 8'h0A);
        pkt(1'b0, 4'd6, 1'b0);
        expect_out("R7 nak", 8'h0A, 0, 0, 0, 1, 1);
        tok(2'd1);
        pkt(1'b1, 4'd6, 1'b0);
        expect_out("R7 nak err", 8'h0A, 0, 0, 0, 1, 3);
    endtask

    task automatic t_out_stall();
        ctl(1'b1, 1'b1, 1'b1);
        tok(2'd1);
        pkt(1'b0, 4'd4, 1'b0);
        expect_out("R8 stall", 8'h0A, 0, 0, 0, 1, 2);
        tok(2'd1);
        pkt(1'b1, 4'd4, 1'b0);
        expect_out("R8 stall err", 8'h0A, 0, 0, 0, 1, 3);
    endtask

    task automatic t_status();
        ctl(1'b0, 1'b1, 1'b0);
        tok(2'd1);
        pkt(1'b0, 4'd2, 1'b1);
        expect_out("R9 status ack", 8'h2A, 1, 0, 0, 1, 0);
        tok(2'd1);
        pkt(1'b0, 4'd4, 1'b0);
        expect_out("R9 nonstatus stall", 8'h42, 1, 0, 0, 1, 2);
        tok(2'd1);
        pkt(1'b1, 4'd6, 1'b1);
        expect_out("R9 err toggle only", 8'h4A, 0, 0, 0, 1, 3);
        tok(2'd1);
        pkt(1'b0, 4'd2, 1'b0);
        expect_out("R9 data0 zero stall", 8'h22, 1, 0, 0, 1, 2);
    endtask

    task automatic t_in_and_stray();
        tok(2'd2);
        chk("R2 in flag", rx_stat, 8'h24);
        pkt(1'b0, 4'd4, 1'b1);
        expect_out("R12 stray done", 8'h24, 0, 0, 0, 0, 0);
        tok(2'd3);
        chk("R2 unused token", rx_stat, 8'h24);
        tok(2'd0);
        chk("R2 setup clears out/in", rx_stat, 8'h21);
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setup_ok();
        t_setup_err();
        t_out_accept();
        t_out_nak();
        t_out_stall();
        t_status();
        t_in_and_stray();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule